// File: doc/BRIEF.md
# Base-and-limit address relocation unit

This unit sits on the request path between a processor and memory and turns each logical address from a user process into a physical address while the program runs. It holds two registers. The base register holds the lowest physical address of the partition given to the process. The limit register holds the size of the logical range that process may use. A user request is first bounded against the limit on its untranslated address. Only a request that passes the bound is relocated by adding the base. A request that fails is blocked, and an addressing-error trap is raised in its place.

Both registers are loaded through a configuration write port, which works only while the supervisor input is high. Supervisor requests skip the bound check and pass their address through unchanged. The path from request to translated request is purely combinational. The translated request and any trap appear in the same cycle as the request, and a new register value applies from the cycle after its write.

Top module: `addr_reloc_unit`

## Requirements
- R1: A user request (supervisor low) is legal only when its logical address, taken as unsigned, is strictly less than the limit register. An address equal to or above the limit raises `trap` and leaves `mem_valid` low.
- R2: A legal user request drives `mem_valid` high in the same cycle, with `mem_paddr` equal to the base register plus the zero-extended logical address (base 14000 with address 346 gives 14346).
- R3: If the base plus logical address carries out of the `PA_W`-bit physical width, the user request raises `trap` and `mem_valid` stays low.
- R4: `trap` and `mem_valid` are never high together, and `trap` is high only in a cycle where `req_valid` is high.
- R5: With `req_valid` low, both `mem_valid` and `trap` are low.
- R6: With `cfg_we` and `supervisor` both high at a rising edge, `cfg_wdata` is loaded into the base register when `cfg_sel` is 0, or its low `LA_W+1` bits into the limit register when `cfg_sel` is 1. The new value governs requests from the next cycle on.
- R7: A configuration write with `supervisor` low changes neither register. Later user requests are still relocated and bounded by the old values.
- R8: A request with `supervisor` high gets no bound check and no relocation. `mem_valid` is high, `trap` is low, and `mem_paddr` is the zero-extended logical address.
- R9: A synchronous reset (rst_n low at a rising edge) clears the base and limit to zero. From then on, every user request traps until the registers are loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supervisor | input | 1 | Privileged mode: enables register writes, bypasses translation |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 limit |
| cfg_wdata | input | PA_W | Register write data |
| req_valid | input | 1 | Processor request present |
| req_laddr | input | LA_W | Logical address of the request |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_paddr | output | PA_W | Physical address to memory |
| trap | output | 1 | Addressing-error trap, one cycle per failing request |

## Verification
The only state is the two registers. A wrong base shows at once as an offset error in `mem_paddr` on the first legal user request after the write. A wrong limit shows as a trap on an address that should pass, or as a pass on one that should trap. Checking both sides of the bound (limit minus one and the limit itself), plus a sum that just fits the physical width and one that just overflows it, exposes an off-by-one or a dropped carry in the same cycle as the request. Writes that leak through without supervisor, and a reset that fails to clear a register, show on the first user request after that stimulus.

// File: rtl/reloc_pkg.sv
// Package: shared types for the relocation unit.
// Assumes: nothing beyond IEEE 1800-2017.
package reloc_pkg;

    // Which configuration register a write targets.
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } cfg_sel_e;

endpackage

// File: rtl/reloc_regs.sv
// Module: reloc_regs
// Holds the base and limit registers. A write lands only when the write
// strobe and the supervisor input are both high at a rising edge.
// Assumes: PA_W >= LIM_W; synchronous active-low reset clears both to zero.
module reloc_regs
    import reloc_pkg::*;
#(
    parameter int PA_W  = 20,
    parameter int LIM_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supervisor,
    input  logic             wr_en,
    input  cfg_sel_e         sel,
    input  logic [PA_W-1:0]  wdata,
    output logic [PA_W-1:0]  base_q,
    output logic [LIM_W-1:0] limit_q
);

    logic wr_ok;

    // Qualify the write with privilege.
    always_comb wr_ok = wr_en && supervisor;

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (wr_ok) begin
            if (sel == SEL_BASE) base_q  <= wdata;
            else                 limit_q <= wdata[LIM_W-1:0];
        end
    end

    // R7: unprivileged writes leave both registers untouched.
    assert_user_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !supervisor) |=> ($stable(base_q) && $stable(limit_q)));

    // R6: a privileged base write is visible the next cycle.
    assert_base_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && supervisor && sel == SEL_BASE) |=> (base_q == $past(wdata)));

    // R6: a privileged limit write is visible the next cycle.
    assert_limit_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && supervisor && sel == SEL_LIMIT) |=> (limit_q == $past(wdata[LIM_W-1:0])));

endmodule

// File: rtl/reloc_bound_check.sv
// Module: reloc_bound_check
// Compares the untranslated logical address against the limit.
// Assumes: LIM_W = LA_W + 1 so a limit of 2**LA_W admits every address.
module reloc_bound_check #(
    parameter int LA_W  = 16,
    parameter int LIM_W = 17
) (
    input  logic [LA_W-1:0]  laddr,
    input  logic [LIM_W-1:0] limit,
    output logic             in_range
);

    // Strict unsigned compare; a zero limit admits nothing.
    always_comb in_range = (LIM_W'(laddr) < limit);

endmodule

// File: rtl/reloc_adder.sv
// Module: reloc_adder
// Adds the base to the zero-extended logical address at physical width
// and reports the carry out of the top bit.
// Assumes: PA_W >= LA_W.
module reloc_adder #(
    parameter int LA_W = 16,
    parameter int PA_W = 20
) (
    input  logic [PA_W-1:0] base,
    input  logic [LA_W-1:0] laddr,
    output logic [PA_W-1:0] sum,
    output logic            carry
);

    logic [PA_W:0] wide;

    // One extra bit holds the carry.
    always_comb begin
        wide  = {1'b0, base} + {1'b0, PA_W'(laddr)};
        sum   = wide[PA_W-1:0];
        carry = wide[PA_W];
    end

endmodule

// File: rtl/addr_reloc_unit.sv
// Module: addr_reloc_unit (top)
// Run-time base-and-limit relocation. A user request is bounded on its
// logical address, then relocated by the base. A failed bound or an
// adder carry blocks the request and pulses trap. Supervisor requests
// pass unchanged. Request-to-output is combinational.
// Assumes: PA_W >= LA_W + 1.
module addr_reloc_unit
    import reloc_pkg::*;
#(
    parameter int LA_W = 16,
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            supervisor,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    input  logic            req_valid,
    input  logic [LA_W-1:0] req_laddr,
    output logic            mem_valid,
    output logic [PA_W-1:0] mem_paddr,
    output logic            trap
);

    localparam int LIM_W = LA_W + 1;

    logic [PA_W-1:0]  base_q;
    logic [LIM_W-1:0] limit_q;
    logic             in_range;
    logic [PA_W-1:0]  reloc_sum;
    logic             reloc_carry;
    logic             user_ok;
    cfg_sel_e         sel_e;

    // Map the raw select bit onto the register enum.
    always_comb sel_e = cfg_sel_e'(cfg_sel);

    reloc_regs #(.PA_W(PA_W), .LIM_W(LIM_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .supervisor (supervisor),
        .wr_en      (cfg_we),
        .sel        (sel_e),
        .wdata      (cfg_wdata),
        .base_q     (base_q),
        .limit_q    (limit_q)
    );

    reloc_bound_check #(.LA_W(LA_W), .LIM_W(LIM_W)) u_bound (
        .laddr    (req_laddr),
        .limit    (limit_q),
        .in_range (in_range)
    );

    reloc_adder #(.LA_W(LA_W), .PA_W(PA_W)) u_add (
        .base  (base_q),
        .laddr (req_laddr),
        .sum   (reloc_sum),
        .carry (reloc_carry)
    );

    // Decide forward or trap, and pick the outgoing address.
    always_comb begin
        user_ok   = in_range && !reloc_carry;
        mem_valid = req_valid && (supervisor || user_ok);
        trap      = req_valid && !supervisor && !user_ok;
        mem_paddr = supervisor ? PA_W'(req_laddr) : reloc_sum;
    end

    // R1: any forwarded user request lies below the limit.
    assert_below_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !supervisor) |-> (LIM_W'(req_laddr) < limit_q));

    // R3: a forwarded user address never wraps below the base.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !supervisor) |-> (mem_paddr >= base_q));

    // R4: trap and forward are exclusive, and trap needs a request.
    assert_trap_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!mem_valid && req_valid));

    // R5: idle cycles produce no output activity.
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_valid && !trap));

    // R8: supervisor requests pass through untouched.
    assert_super_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && supervisor) |-> (mem_valid && !trap && mem_paddr == PA_W'(req_laddr)));

endmodule

// File: tb/addr_reloc_unit_bench.sv
`timescale 1ns/1ps
module addr_reloc_unit_bench;

    localparam int LA_W = 16;
    localparam int PA_W = 20;
    localparam int LIM_W = LA_W + 1;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LIM_W-1:0] lim;
        logic             sup;
        logic [LA_W-1:0]  la;
        logic             ev;
        logic             et;
        logic [PA_W-1:0]  epa;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{20'h036B0, 17'd1000,    1'b0, 16'd346,    1'b1, 1'b0, 20'd14346},  // R2
        '{20'h036B0, 17'd1000,    1'b0, 16'd999,    1'b1, 1'b0, 20'd14999},  // R1 edge legal
        '{20'h036B0, 17'd1000,    1'b0, 16'd1000,   1'b0, 1'b1, 20'd0},      // R1 equal traps
        '{20'h036B0, 17'd1000,    1'b0, 16'hFFFF,   1'b0, 1'b1, 20'd0},      // R1 far out
        '{20'h036B0, 17'd1000,    1'b1, 16'hFFFF,   1'b1, 1'b0, 20'h0FFFF},  // R8
        '{20'hFFF00, 17'h00400,   1'b0, 16'h00FF,   1'b1, 1'b0, 20'hFFFFF},  // R3 just fits
        '{20'hFFF00, 17'h00400,   1'b0, 16'h0100,   1'b0, 1'b1, 20'd0},      // R3 carry
        '{20'h00000, 17'h10000,   1'b0, 16'hFFFF,   1'b1, 1'b0, 20'h0FFFF},  // R1 full range
        '{20'h12345, 17'h00000,   1'b0, 16'h0000,   1'b0, 1'b1, 20'd0},      // R1 zero limit
        '{20'hFFF00, 17'h00400,   1'b1, 16'h0100,   1'b1, 1'b0, 20'h00100}   // R8 no carry check
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            supervisor;
    logic            cfg_we;
    logic            cfg_sel;
    logic [PA_W-1:0] cfg_wdata;
    logic            req_valid;
    logic [LA_W-1:0] req_laddr;
    logic            mem_valid;
    logic [PA_W-1:0] mem_paddr;
    logic            trap;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    addr_reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) u_addr_reloc_unit (
        .clk(clk), .rst_n(rst_n), .supervisor(supervisor), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_laddr(req_laddr), .mem_valid(mem_valid), .mem_paddr(mem_paddr),
        .trap(trap)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic program_regs(input logic [PA_W-1:0] b, input logic [LIM_W-1:0] l);
        @(negedge clk);
        req_valid = 1'b0; supervisor = 1'b1; cfg_we = 1'b1;
        cfg_sel = 1'b0; cfg_wdata = b;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wdata = PA_W'(l);
        @(negedge clk);
        cfg_we = 1'b0; supervisor = 1'b0;
    endtask

    task automatic request(input logic sup, input logic [LA_W-1:0] a);
        supervisor = sup; req_valid = 1'b1; req_laddr = a;
        #1;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supervisor = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0;
        cfg_wdata = '0; req_valid = 1'b0; req_laddr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: idle after reset
        #1;
        chk("R5 idle mem_valid", 32'(mem_valid), 32'd0);
        chk("R5 idle trap", 32'(trap), 32'd0);

        // R9: reset state traps any user request
        request(1'b0, 16'd0);
        chk("R9 reset trap", 32'(trap), 32'd1);
        chk("R9 reset mem_valid", 32'(mem_valid), 32'd0);
        @(negedge clk); req_valid = 1'b0;

        // Table walk (R1 R2 R3 R4 R6 R8)
        for (int i = 0; i < NV; i++) begin
            program_regs(TBL[i].base, TBL[i].lim);
            request(TBL[i].sup, TBL[i].la);
            chk($sformatf("R6/R1/R2 vec %0d mem_valid", i), 32'(mem_valid), 32'(TBL[i].ev));
            chk($sformatf("R4 vec %0d trap", i), 32'(trap), 32'(TBL[i].et));
            if (TBL[i].ev)
                chk($sformatf("R2/R8 vec %0d paddr", i), 32'(mem_paddr), 32'(TBL[i].epa));
            @(negedge clk); req_valid = 1'b0;
        end

        // R7: unprivileged writes ignored
        program_regs(20'h00100, 17'd100);
        supervisor = 1'b0; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 20'h05000;
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wdata = 20'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        request(1'b0, 16'd10);
        chk("R7 base kept paddr", 32'(mem_paddr), 32'h0010A);
        chk("R7 limit kept valid", 32'(mem_valid), 32'd1);
        @(negedge clk); req_valid = 1'b0;

        // R9: reset mid-run clears registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        request(1'b0, 16'd10);
        chk("R9 re-reset trap", 32'(trap), 32'd1);
        @(negedge clk); req_valid = 1'b0;
        #1;
        chk("R5 idle after trap", 32'(trap), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule